// File: doc/BRIEF.md
# Receive Data Output Conditioner

This block sits between a synchronised demodulator bit and the data line that a host watches while the receiver is in receiving mode. The line changes state only on the ticks of a slow extended clock. After each change it holds the new level for a programmable number of ticks. That hold keeps narrow spikes off the line and bounds the rate of edges the host must service. The block also limits how long the line may stay low, so the host always gets a bounded response when it reuses the line for control.

The hold length after an edge depends on the interval that edge closed. If the tick count since the previous edge falls inside the bit-check window, one hold value applies. Otherwise a second value applies. When the low limit runs out, the line is forced high and stays high until the demodulator has been seen high again. Outside receiving mode the line idles high, so the first low level after entry is a falling edge that can wake the host.

Top module: `rx_data_cond`

## Requirements
- R1: While rst_n is low, data_out is 1, and it is 1 on the first clock after reset is released.
- R2: On the clock after any clock edge where rx_mode is 0, data_out is 1, whatever tick and dem_bit are doing.
- R3: data_out changes only on a clock edge where both tick and rx_mode are 1.
- R4: On a tick in receiving mode with no hold, cap or lock-out active, data_out takes the value of dem_bit on that clock edge.
- R5: The interval closed by a normal edge is the number of ticks since the previous edge. If lim_lo <= interval <= lim_hi (inclusive), the next normal edge may come no earlier than hold_in ticks after this edge. Otherwise it may come no earlier than hold_out ticks after it. The gap is never less than 1 tick.
- R6: The first edge after entering receiving mode closes an interval of 0 ticks.
- R7: On entry to receiving mode with dem_bit low, data_out falls on the first tick.
- R8: data_out stays low for at most max(low_cap,1) ticks. On the tick that reaches this count, it is forced to 1.
- R9: After a forced rise, data_out stays 1 until a tick sees dem_bit at 1. A later tick with dem_bit at 0 then lowers it, with no hold.
- R10: When the low cap expires during a hold, the cap wins and data_out rises on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Extended-clock tick enable, one clock wide |
| rx_mode | input | 1 | High while in receiving mode |
| dem_bit | input | 1 | Synchronised demodulator bit |
| lim_lo | input | W | Lower bit-check limit, in ticks |
| lim_hi | input | W | Upper bit-check limit, in ticks |
| hold_in | input | W | Hold after an interval inside the limits, in ticks |
| hold_out | input | W | Hold after an interval outside the limits, in ticks |
| low_cap | input | W | Maximum low time, in ticks |
| data_out | output | 1 | Conditioned data line |

## Verification
Two functions can act on the same tick: the hold that follows a falling edge and the low-time cap. The bench provokes the clash on purpose. It sets low_cap below hold_out and holds the demodulator low after the line falls, so the cap expires while the hold counter is still running. Under R10 the line must then rise on exactly the tick at which the low count reaches the cap. The hold counter must not delay that rise. The bench also judges that the line does not drop again until the demodulator has gone high.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_FOLLOW,
        ACT_CAP,
        ACT_LOCK
    } act_e;
endpackage

// File: rtl/rdc_ivl_meter.sv
module rdc_ivl_meter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr,
    input  logic         edge_ev,
    input  logic [W-1:0] lim_lo,
    input  logic [W-1:0] lim_hi,
    output logic         in_lim
);
    localparam int CW = W + 1;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] ivl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.ivl = '0;
        end else if (tick) begin
            if (edge_ev) begin
                st_d.ivl = CW'(1);
            end else if (st_q.ivl != CMAX) begin
                st_d.ivl = st_q.ivl + CW'(1);
            end
        end
        in_lim = (st_q.ivl >= {1'b0, lim_lo}) && (st_q.ivl <= {1'b0, lim_hi});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rdc_hold_timer.sv
module rdc_hold_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         blocked
);
    typedef struct packed {
        logic [W-1:0] frz;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.frz = '0;
        end else if (tick) begin
            if (load)                 st_d.frz = load_val;
            else if (st_q.frz > W'(1)) st_d.frz = st_q.frz - W'(1);
            else                      st_d.frz = '0;
        end
        blocked = st_q.frz > W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rdc_low_guard.sv
module rdc_low_guard #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr,
    input  logic         line_q,
    input  logic         go_low,
    input  logic         dem_bit,
    input  logic [W-1:0] low_cap,
    output logic         expire,
    output logic         lockout
);
    localparam int CW = W + 1;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] lowc;
        logic          lock;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = tick && !line_q && (st_q.lowc >= {1'b0, low_cap});
        if (clr) begin
            st_d = '0;
        end else if (tick) begin
            if (go_low)                             st_d.lowc = CW'(1);
            else if (!line_q && st_q.lowc != CMAX)  st_d.lowc = st_q.lowc + CW'(1);
            else if (line_q)                        st_d.lowc = '0;
            if (expire)       st_d.lock = 1'b1;
            else if (dem_bit) st_d.lock = 1'b0;
        end
        lockout = st_q.lock;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rx_data_cond.sv
module rx_data_cond
    import rdc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         rx_mode,
    input  logic         dem_bit,
    input  logic [W-1:0] lim_lo,
    input  logic [W-1:0] lim_hi,
    input  logic [W-1:0] hold_in,
    input  logic [W-1:0] hold_out,
    input  logic [W-1:0] low_cap,
    output logic         data_out
);
    typedef struct packed {
        logic data;
    } st_t;

    st_t          st_d, st_q;
    act_e         act;
    logic         clr, in_lim, blocked, expire, lockout;
    logic         edge_ev, go_low;
    logic [W-1:0] hold_val;

    assign clr = !rx_mode;

    rdc_ivl_meter #(.W(W)) u_ivl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .edge_ev(edge_ev),
        .lim_lo(lim_lo), .lim_hi(lim_hi), .in_lim(in_lim)
    );

    rdc_hold_timer #(.W(W)) u_hold (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .load(edge_ev),
        .load_val(hold_val), .blocked(blocked)
    );

    rdc_low_guard #(.W(W)) u_low (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .line_q(st_q.data),
        .go_low(go_low), .dem_bit(dem_bit), .low_cap(low_cap),
        .expire(expire), .lockout(lockout)
    );

    always_comb begin
        st_d = st_q;
        act  = ACT_IDLE;
        if (!rx_mode) begin
            st_d.data = 1'b1;
        end else if (tick) begin
            if (expire) begin
                act       = ACT_CAP;
                st_d.data = 1'b1;
            end else if (lockout) begin
                act = ACT_LOCK;
            end else if (!blocked && (dem_bit != st_q.data)) begin
                act       = ACT_FOLLOW;
                st_d.data = dem_bit;
            end
        end
        edge_ev  = (act == ACT_FOLLOW) || (act == ACT_CAP);
        go_low   = (act == ACT_FOLLOW) && !dem_bit;
        hold_val = (act == ACT_CAP) ? '0 : (in_lim ? hold_in : hold_out);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{data: 1'b1};
        else        st_q <= st_d;
    end

    assign data_out = st_q.data;
endmodule

// File: rtl/rdc_chk.sv
module rdc_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         rx_mode,
    input logic         dem_bit,
    input logic [W-1:0] low_cap,
    input logic         data_out
);
    logic [W+1:0] lc;
    logic [W+1:0] cap_eff;
    logic         prev_out, dem_at, capped;

    assign cap_eff = (low_cap == '0) ? (W+2)'(1) : {2'b00, low_cap};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lc       <= '0;
            prev_out <= 1'b1;
            dem_at   <= 1'b1;
            capped   <= 1'b0;
        end else begin
            prev_out <= data_out;
            dem_at   <= dem_bit;
            if (!rx_mode || data_out)        lc <= '0;
            else if (tick && lc != '1)       lc <= lc + 1'b1;
            if (!rx_mode)                                capped <= 1'b0;
            else if (tick && dem_bit)                    capped <= 1'b0;
            else if (data_out && !prev_out && !dem_at)   capped <= 1'b1;
        end
    end

    p_reset_high_r1: assert property (@(posedge clk) !rst_n |=> data_out);

    p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_mode |=> data_out);

    p_tick_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && rx_mode) |=> $stable(data_out));

    p_low_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lc <= cap_eff);

    p_lock_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        capped |-> data_out);
endmodule

bind rx_data_cond rdc_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_mode(rx_mode),
    .dem_bit(dem_bit), .low_cap(low_cap), .data_out(data_out)
);

// File: tb/rx_data_cond_tb.sv
module rx_data_cond_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         rx_mode = 1'b0;
    logic         dem_bit = 1'b1;
    logic [W-1:0] lim_lo = 8'd4, lim_hi = 8'd6, hold_in = 8'd3, hold_out = 8'd2, low_cap = 8'd50;
    logic         data_out;

    int checks = 0, errors = 0;
    string tag = "R1";
    bit   m_out = 1'b1, m_lock = 1'b0;
    int   m_since = 0, m_min = 0, m_low = 0;

    always #10 clk = ~clk;

    rx_data_cond #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_mode(rx_mode), .dem_bit(dem_bit),
        .lim_lo(lim_lo), .lim_hi(lim_hi), .hold_in(hold_in), .hold_out(hold_out),
        .low_cap(low_cap), .data_out(data_out)
    );

    function automatic int cap_eff(input int c);
        return (c == 0) ? 1 : c;
    endfunction

    function automatic bit inside_lim(input int iv, input int lo, input int hi);
        return (iv >= lo) && (iv <= hi);
    endfunction

    // reference behaviour from the requirements
    always @(posedge clk) begin
        if (!rst_n || !rx_mode) begin
            m_out = 1'b1; m_lock = 1'b0; m_since = 0; m_min = 0; m_low = 0;
        end else if (tick) begin
            if (!m_out) m_low++;
            if (!m_out && m_low >= cap_eff(int'(low_cap))) begin
                m_out = 1'b1; m_lock = 1'b1; m_since = 1; m_min = 0;
            end else if (m_lock) begin
                if (dem_bit) m_lock = 1'b0;
                m_since++;
            end else if (dem_bit != m_out && m_since >= m_min) begin
                m_min  = inside_lim(m_since, int'(lim_lo), int'(lim_hi)) ? int'(hold_in) : int'(hold_out);
                m_out  = dem_bit;
                m_since = 1;
                m_low  = 0;
            end else begin
                m_since++;
            end
        end
    end

    task automatic check(input string req, input bit exp);
        checks++;
        if (data_out !== exp) begin
            errors++;
            $display("FAIL %s data_out=%0b expected=%0b at %0t", req, data_out, exp, $time);
        end
    endtask

    task automatic step(input bit t, input bit d);
        tick = t; dem_bit = d;
        @(negedge clk);
        check(tag, m_out);
    endtask

    initial begin
        #(20 * 180000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check("R1", 1'b1);                       // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b1);

        // R2: idle high outside receiving mode
        tag = "R2";
        for (int i = 0; i < 40; i++) begin
            step(1'b1, i[0]);
            check("R2", 1'b1);
        end

        // R7 and R6: entry with demodulator low -> fall on first tick
        tag = "R7";
        lim_lo = 8'd0; lim_hi = 8'd0; hold_in = 8'd9; hold_out = 8'd2; low_cap = 8'd40;
        rx_mode = 1'b1;
        step(1'b0, 1'b0);
        check("R3", 1'b1);
        step(1'b1, 1'b0);
        check("R7", 1'b0);
        // interval 0 was inside [0,0] -> hold_in=9 ticks (R6)
        tag = "R6";
        for (int i = 1; i < 9; i++) begin
            step(1'b1, 1'b1);
            check("R6", 1'b0);
        end
        step(1'b1, 1'b1);
        check("R6", 1'b1);

        // R10: cap shorter than hold
        tag = "R10";
        rx_mode = 1'b0; step(1'b0, 1'b1);
        lim_lo = 8'd50; lim_hi = 8'd60; hold_out = 8'd20; low_cap = 8'd3;
        rx_mode = 1'b1;
        step(1'b1, 1'b0);
        check("R10", 1'b0);
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0);
        check("R10", 1'b0);
        step(1'b1, 1'b0);
        check("R10", 1'b1);
        // R9: lock-out until demodulator is seen high
        tag = "R9";
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 1'b0);
            check("R9", 1'b1);
        end
        step(1'b1, 1'b1);
        check("R9", 1'b1);
        step(1'b1, 1'b0);
        check("R9", 1'b0);

        // R8: cap of zero means one tick
        tag = "R8";
        rx_mode = 1'b0; step(1'b0, 1'b1);
        low_cap = 8'd0; hold_out = 8'd0;
        rx_mode = 1'b1;
        step(1'b1, 1'b0);
        check("R8", 1'b0);
        step(1'b1, 1'b0);
        check("R8", 1'b1);

        // R4 R5 R3: constrained random segments
        for (int s = 0; s < 40; s++) begin
            rx_mode = 1'b0;
            step(1'b0, 1'b1);
            lim_lo   = W'(1 + $urandom % 8);
            lim_hi   = lim_lo + W'($urandom % 8);
            hold_in  = W'($urandom % 7);
            hold_out = W'($urandom % 7);
            low_cap  = W'(($urandom % 4 == 0) ? 2 + $urandom % 6 : 10 + $urandom % 40);
            rx_mode  = 1'b1;
            tag = (s % 2 == 0) ? "R5" : "R4";
            begin
                bit d = 1'b1;
                int run = 0;
                for (int c = 0; c < 800; c++) begin
                    if (run == 0) begin
                        d   = ~d;
                        run = ($urandom % 5 == 0) ? 1 + $urandom % 2 : 1 + $urandom % 30;
                    end
                    run--;
                    tag = (s % 3 == 0) ? "R3" : tag;
                    step(($urandom % 3) == 0, d);
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule